// File: doc/BRIEF.md
# Time-of-Day Counter with Clock-Domain Start/Stop Handshake

This block keeps seconds, minutes, hours and a day-of-week index in BCD, advancing once per second. A slow free-running count-source signal is the time base, and a fast bus clock runs the register port. The count source is sampled into the bus clock. Each of its rising edges becomes a one-cycle tick, and a selectable number of ticks makes one second.

Software starts and stops counting by writing a request bit. A separate read-only status bit reports when counting has really begun or ended. The status bit trails the request bit by a different number of count-source cycles on start and on stop. Time, hour-format, AM/PM, compare-enable and source-select fields accept writes only while the counter is fully stopped. The three compare registers accept writes only while the busy flag is clear. When the enabled compare fields equal the freshly updated time, the block emits a one-cycle interrupt pulse.

Top module: `rtc_top`

## Requirements
- R1: Writing 1 to the run request (control register, address 4, bit 0) makes the status bit (address 4, bit 1) rise after at most two count-source rising edges. Time does not advance before the status bit is 1.
- R2: Writing 0 to the run request makes the status bit fall after two to three count-source rising edges. Once it has fallen, time stays frozen.
- R3: The counter is stopped only when both the run request and the status bit are 0. Only then are writes honoured to seconds (address 0, bits 6:0), minutes (address 1), hours (address 2, bits 5:0), day (address 3, bits 2:0), 12-hour mode (address 4, bit 2), PM (address 4, bit 3), source select (address 4, bits 5:4) and compare enables (address 5: bit 0 seconds, bit 1 minutes, bit 2 hours). Other writes to these fields are dropped and the old value is kept.
- R4: Compare seconds, minutes and hours (addresses 6, 7, 8) accept writes only while busy (address 0, bit 7) is 0. A write made while busy is 1 is dropped.
- R5: In 24-hour mode, seconds and minutes count BCD 00 to 59, and hours count 00 to 23. The step from 23:59:59 gives 00:00:00 and advances the day. Day 6 wraps to 0.
- R6: In 12-hour mode, hour 11 steps to 12 and inverts PM, and hour 12 steps to 01. The step from 11 PM to 12 AM also advances the day.
- R7: One second lasts 2^(sel+1) count-source cycles, where sel is the source-select field.
- R8: After each one-second update, if at least one compare enable is set and every enabled compare register equals its time field, irq is high for exactly one bus cycle. The hours comparison ignores PM. With no enable set, irq stays 0.
- R9: After reset, every register reads 0 and irq is 0.
- R10: While running, busy is 1 for the one count-source cycle just before each seconds update and falls at the moment the seconds value changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_src | input | 1 | Slow count-source signal, sampled on clk |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | One-cycle compare-match pulse |

## Verification
The hardest case to reach from the ports is a compare-register write that lands inside the short busy window. That window lasts one count-source cycle before each seconds step and has no fixed phase relative to the bus. The bench polls the seconds register every bus cycle until it sees bit 7 rise, then issues the write on the very next cycle, while busy is still high, and reads back the old value. The same polling measures the busy width in bus cycles. It also measures the status latency on start and on stop, counting count-source edges from the write edge onward.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADR_SEC   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MIN   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_HOUR  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_DOW   = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CMPEN = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_CSEC  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CMIN  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_CHR   = 4'd8;

  // two-digit BCD increment without range wrap
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tick
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign tick = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rtc_runctl.sv
module rtc_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_req,
  output logic status
);
  logic [1:0] pipe_q, pipe_d;
  logic       stat_q, stat_d;

  // rising path looks at stage 0, falling path at stage 1: 2 ticks up, 3 down
  always_comb begin
    pipe_d = pipe_q;
    stat_d = stat_q;
    if (tick) begin
      pipe_d = {pipe_q[0], start_req};
      stat_d = stat_q ? pipe_q[1] : pipe_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      stat_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;

  AST_STATUS_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> start_req); // R1
  AST_STATUS_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> !start_req); // R2
  AST_STATUS_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(stat_q)); // R1
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
  import rtc_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             running,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             mode12,
  input  logic             ld_sec,
  input  logic             ld_min,
  input  logic             ld_hour,
  input  logic             ld_dow,
  input  logic             ld_pm,
  input  logic [7:0]       wdata,
  input  logic             pm_wr,
  output logic [6:0]       sec,
  output logic [6:0]       min,
  output logic [5:0]       hour,
  output logic [2:0]       dow,
  output logic             pm,
  output logic             busy,
  output logic             upd
);
  localparam int PRESC_W = 1 << SEL_W;

  logic [PRESC_W-1:0] presc_q, presc_d, limit;
  logic [6:0] sec_q, sec_d, min_q, min_d;
  logic [5:0] hour_q, hour_d;
  logic [2:0] dow_q, dow_d;
  logic       pm_q, pm_d;
  logic       day_roll;

  always_comb begin
    limit = PRESC_W'((32'd2 << src_sel) - 32'd1);
  end

  always_comb begin
    presc_d  = presc_q;
    sec_d    = sec_q;
    min_d    = min_q;
    hour_d   = hour_q;
    dow_d    = dow_q;
    pm_d     = pm_q;
    upd      = 1'b0;
    day_roll = 1'b0;
    if (!running) begin
      presc_d = '0;
    end else if (tick) begin
      if (presc_q == limit) begin
        presc_d = '0;
        upd     = 1'b1;
        if (sec_q == 7'h59) begin
          sec_d = '0;
          if (min_q == 7'h59) begin
            min_d = '0;
            if (mode12) begin
              if (hour_q == 6'h12) begin
                hour_d = 6'h01;
              end else if (hour_q == 6'h11) begin
                hour_d   = 6'h12;
                pm_d     = ~pm_q;
                day_roll = pm_q;
              end else begin
                hour_d = 6'(bcd_inc({2'b00, hour_q}));
              end
            end else begin
              if (hour_q == 6'h23) begin
                hour_d   = '0;
                day_roll = 1'b1;
              end else begin
                hour_d = 6'(bcd_inc({2'b00, hour_q}));
              end
            end
          end else begin
            min_d = 7'(bcd_inc({1'b0, min_q}));
          end
        end else begin
          sec_d = 7'(bcd_inc({1'b0, sec_q}));
        end
      end else begin
        presc_d = presc_q + 1'b1;
      end
    end
    if (day_roll) dow_d = (dow_q == 3'd6) ? 3'd0 : dow_q + 3'd1;
    if (ld_sec)  sec_d  = wdata[6:0];
    if (ld_min)  min_d  = wdata[6:0];
    if (ld_hour) hour_d = wdata[5:0];
    if (ld_dow)  dow_d  = wdata[2:0];
    if (ld_pm)   pm_d   = pm_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      sec_q   <= '0;
      min_q   <= '0;
      hour_q  <= '0;
      dow_q   <= '0;
      pm_q    <= 1'b0;
    end else begin
      presc_q <= presc_d;
      sec_q   <= sec_d;
      min_q   <= min_d;
      hour_q  <= hour_d;
      dow_q   <= dow_d;
      pm_q    <= pm_d;
    end
  end

  assign busy = running && (presc_q == limit);
  assign sec  = sec_q;
  assign min  = min_q;
  assign hour = hour_q;
  assign dow  = dow_q;
  assign pm   = pm_q;

  AST_LOAD_ONLY_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sec || ld_min || ld_hour || ld_dow || ld_pm) |-> !running); // R3
  AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ld_sec) |=> $stable(sec_q)); // R2
  AST_BUSY_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> running); // R10
  AST_UPDATE_MOVES_SECONDS: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (sec_q != $past(sec_q))); // R5
endmodule

// File: rtl/rtc_match.sv
module rtc_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [2:0] en,
  input  logic [6:0] sec,
  input  logic [6:0] min,
  input  logic [5:0] hour,
  input  logic [6:0] csec,
  input  logic [6:0] cmin,
  input  logic [5:0] chr,
  output logic       irq
);
  logic upd_q;
  logic irq_q, irq_d;
  logic [2:0] hit;

  always_comb begin
    hit[0] = !en[0] || (sec  == csec);
    hit[1] = !en[1] || (min  == cmin);
    hit[2] = !en[2] || (hour == chr);
    irq_d  = upd_q && (|en) && (&hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      upd_q <= upd;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_IRQ_FOLLOWS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(upd, 2)); // R8
endmodule

// File: rtl/rtc_top.sv
module rtc_top
  import rtc_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_src,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic tick, status, busy, upd, pm;
  logic [6:0] sec, min;
  logic [5:0] hour;
  logic [2:0] dow;

  logic             start_q, start_d, mode12_q, mode12_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [2:0]       cmpen_q, cmpen_d;
  logic [6:0]       csec_q, csec_d, cmin_q, cmin_d;
  logic [5:0]       chr_q, chr_d;
  logic             stopped, wr_time_ok, wr_cmp_ok;
  logic             ld_sec, ld_min, ld_hour, ld_dow, ld_pm;

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .din(cnt_src), .tick(tick)
  );

  rtc_runctl u_run (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .start_req(start_q), .status(status)
  );

  rtc_timekeep #(.SEL_W(SEL_W)) u_time (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .running(status),
    .src_sel(sel_q), .mode12(mode12_q),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow), .ld_pm(ld_pm),
    .wdata(wdata), .pm_wr(wdata[3]),
    .sec(sec), .min(min), .hour(hour), .dow(dow), .pm(pm), .busy(busy), .upd(upd)
  );

  rtc_match u_match (
    .clk(clk), .rst_n(rst_core_n), .upd(upd), .en(cmpen_q),
    .sec(sec), .min(min), .hour(hour),
    .csec(csec_q), .cmin(cmin_q), .chr(chr_q), .irq(irq)
  );

  always_comb begin
    stopped    = !start_q && !status;
    wr_time_ok = we && stopped;
    wr_cmp_ok  = we && !busy;
    ld_sec     = wr_time_ok && (addr == ADR_SEC);
    ld_min     = wr_time_ok && (addr == ADR_MIN);
    ld_hour    = wr_time_ok && (addr == ADR_HOUR);
    ld_dow     = wr_time_ok && (addr == ADR_DOW);
    ld_pm      = wr_time_ok && (addr == ADR_CTRL);
  end

  always_comb begin
    start_d  = start_q;
    mode12_d = mode12_q;
    sel_d    = sel_q;
    cmpen_d  = cmpen_q;
    csec_d   = csec_q;
    cmin_d   = cmin_q;
    chr_d    = chr_q;
    if (we && (addr == ADR_CTRL)) start_d = wdata[0];
    if (wr_time_ok && (addr == ADR_CTRL)) begin
      mode12_d = wdata[2];
      sel_d    = wdata[4 +: SEL_W];
    end
    if (wr_time_ok && (addr == ADR_CMPEN)) cmpen_d = wdata[2:0];
    if (wr_cmp_ok && (addr == ADR_CSEC)) csec_d = wdata[6:0];
    if (wr_cmp_ok && (addr == ADR_CMIN)) cmin_d = wdata[6:0];
    if (wr_cmp_ok && (addr == ADR_CHR))  chr_d  = wdata[5:0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      start_q  <= 1'b0;
      mode12_q <= 1'b0;
      sel_q    <= '0;
      cmpen_q  <= '0;
      csec_q   <= '0;
      cmin_q   <= '0;
      chr_q    <= '0;
    end else begin
      start_q  <= start_d;
      mode12_q <= mode12_d;
      sel_q    <= sel_d;
      cmpen_q  <= cmpen_d;
      csec_q   <= csec_d;
      cmin_q   <= cmin_d;
      chr_q    <= chr_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADR_SEC:   rdata = {busy, sec};
      ADR_MIN:   rdata = {1'b0, min};
      ADR_HOUR:  rdata = {2'b00, hour};
      ADR_DOW:   rdata = {5'd0, dow};
      ADR_CTRL:  rdata = DATA_W'({sel_q, pm, mode12_q, status, start_q});
      ADR_CMPEN: rdata = {5'd0, cmpen_q};
      ADR_CSEC:  rdata = {1'b0, csec_q};
      ADR_CMIN:  rdata = {1'b0, cmin_q};
      ADR_CHR:   rdata = {2'b00, chr_q};
      default:   rdata = '0;
    endcase
  end

  AST_CMP_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(csec_q) |-> $past(!busy)); // R4
  AST_MODE_HELD_UNLESS_STOPPED: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(mode12_q) |-> $past(!status)); // R3
endmodule

// File: tb/rtc_top_bench.sv
module rtc_top_bench;
  import rtc_pkg::*;

  logic clk = 1'b0;
  logic cnt_src = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;

  int n_chk = 0, n_err = 0;
  int edge_cnt = 0, cyc = 0, irq_cnt = 0, irq_wide = 0;
  logic irq_prev = 1'b0;
  logic [7:0] sb_exp[$];
  string sb_tag[$];
  logic [3:0] sb_adr[$];

  rtc_top u_rtc_top (
    .clk(clk), .rst_n(rst_n), .cnt_src(cnt_src), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;
  always #80 cnt_src = ~cnt_src;
  always @(posedge cnt_src) edge_cnt++;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (irq) begin
      irq_cnt++;
      if (irq_prev) irq_wide++;
    end
    irq_prev = irq;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected read per cycle
  initial forever begin
    @(negedge clk);
    #2;
    if (sb_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      logic [3:0] a;
      e = sb_exp.pop_front();
      t = sb_tag.pop_front();
      a = sb_adr.pop_front();
      chk(rdata == e, $sformatf("%s addr%0d", t, a), rdata, e);
    end
  end

  task automatic expect_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    addr = a;
    sb_exp.push_back(e);
    sb_tag.push_back(tag);
    sb_adr.push_back(a);
    #4;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #2;
    v = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // write control and count count-source edges until status matches bit 0
  task automatic set_run(input logic [7:0] d, output int edges, output bit ok);
    int e0;
    logic [7:0] v;
    @(negedge clk);
    we = 1'b1; addr = ADR_CTRL; wdata = d;
    @(posedge clk);
    e0 = edge_cnt;
    @(negedge clk);
    we = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 200 && !ok; i++) begin
      rd(ADR_CTRL, v);
      if (v[1] == d[0]) ok = 1'b1;
    end
    edges = edge_cnt - e0;
  endtask

  task automatic wait_sec(input logic [6:0] target, output bit ok);
    logic [7:0] v;
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      rd(ADR_SEC, v);
      if (v[6:0] == target) ok = 1'b1;
    end
  endtask

  task automatic wait_busy(input logic lvl, output logic [7:0] v);
    bit got;
    got = 1'b0;
    for (int i = 0; i < 500 && !got; i++) begin
      rd(ADR_SEC, v);
      if (v[7] == lvl) got = 1'b1;
    end
  endtask

  function automatic logic [6:0] inc60(input logic [6:0] s);
    if (s == 7'h59) return 7'h00;
    if (s[3:0] == 4'd9) return {s[6:4] + 3'd1, 4'd0};
    return {s[6:4], s[3:0] + 4'd1};
  endfunction

  task automatic load_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                           input logic [7:0] d);
    wr(ADR_HOUR, h); wr(ADR_MIN, m); wr(ADR_SEC, s); wr(ADR_DOW, d);
  endtask

  task automatic measure(input int sel);
    int edges, c0, c1;
    bit ok;
    logic [7:0] v, v0;
    set_run(8'h00, edges, ok);
    wr(ADR_CTRL, 8'(sel << 4));
    set_run(8'(sel << 4) | 8'h01, edges, ok);
    rd(ADR_SEC, v0);
    for (int i = 0; i < 2000; i++) begin rd(ADR_SEC, v); if (v[6:0] != v0[6:0]) break; end
    c0 = cyc; v0 = v;
    for (int i = 0; i < 2000; i++) begin rd(ADR_SEC, v); if (v[6:0] != v0[6:0]) break; end
    c1 = cyc;
    chk((c1 - c0) == 8 * (2 << sel), $sformatf("R7 second period sel=%0d", sel),
        c1 - c0, 8 * (2 << sel));
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int edges, w, c0;
    bit ok;
    logic [7:0] v, s0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    expect_rd(ADR_SEC, 8'h00, "R9 reset");
    expect_rd(ADR_MIN, 8'h00, "R9 reset");
    expect_rd(ADR_HOUR, 8'h00, "R9 reset");
    expect_rd(ADR_DOW, 8'h00, "R9 reset");
    expect_rd(ADR_CTRL, 8'h00, "R9 reset");
    expect_rd(ADR_CMPEN, 8'h00, "R9 reset");
    chk(irq == 1'b0, "R9 irq reset", irq, 0);

    // R3 writes honoured while stopped
    load_time(8'h23, 8'h59, 8'h58, 8'h06);
    expect_rd(ADR_HOUR, 8'h23, "R3 stopped write");
    expect_rd(ADR_SEC, 8'h58, "R3 stopped write");
    expect_rd(ADR_DOW, 8'h06, "R3 stopped write");

    // R1 start latency
    set_run(8'h01, edges, ok);
    chk(ok && edges >= 1 && edges <= 2, "R1 start latency edges", edges, 2);
    expect_rd(ADR_SEC, 8'h58, "R1 no count before status");

    // R3 writes ignored while running
    wr(ADR_HOUR, 8'h05);
    expect_rd(ADR_HOUR, 8'h23, "R3 hour write ignored");
    wr(ADR_CTRL, 8'h05);
    expect_rd(ADR_CTRL, 8'h03, "R3 mode write ignored");
    wr(ADR_CMPEN, 8'h07);
    expect_rd(ADR_CMPEN, 8'h00, "R3 enable write ignored");

    // R5 day rollover
    wait_sec(7'h00, ok);
    chk(ok, "R5 reached 00 seconds", ok, 1);
    expect_rd(ADR_MIN, 8'h00, "R5 minute wrap");
    expect_rd(ADR_HOUR, 8'h00, "R5 hour wrap");
    expect_rd(ADR_DOW, 8'h00, "R5 day 6 wraps to 0");

    // R10 busy width and alignment with the seconds step
    wait_busy(1'b0, v);
    wait_busy(1'b1, v);
    s0 = v; c0 = cyc;
    wait_busy(1'b0, v);
    w = cyc - c0;
    chk(w == 8, "R10 busy width cycles", w, 8);
    chk(v[6:0] == inc60(s0[6:0]), "R10 seconds step at busy fall", v[6:0], inc60(s0[6:0]));

    // R4 compare write accepted when not busy, dropped while busy
    wr(ADR_CSEC, 8'h30);
    expect_rd(ADR_CSEC, 8'h30, "R4 write while idle");
    wait_busy(1'b0, v);
    wait_busy(1'b1, v);
    wr(ADR_CSEC, 8'h45);
    expect_rd(ADR_CSEC, 8'h30, "R4 write while busy dropped");
    chk(irq_cnt == 0, "R8 no enables no irq", irq_cnt, 0);

    // R2 stop latency and freeze
    set_run(8'h00, edges, ok);
    chk(ok && edges >= 2 && edges <= 3, "R2 stop latency edges", edges, 3);
    rd(ADR_SEC, s0);
    repeat (100) @(negedge clk);
    expect_rd(ADR_SEC, s0, "R2 frozen after stop");

    // R8 seconds-only compare
    load_time(8'h00, 8'h00, 8'h00, 8'h00);
    wr(ADR_CSEC, 8'h03);
    wr(ADR_CMPEN, 8'h01);
    irq_cnt = 0;
    set_run(8'h01, edges, ok);
    wait_sec(7'h02, ok);
    chk(irq_cnt == 0, "R8 no match before 03", irq_cnt, 0);
    wait_sec(7'h04, ok);
    chk(irq_cnt == 1, "R8 single match at 03", irq_cnt, 1);

    // R8 all fields enabled
    set_run(8'h00, edges, ok);
    load_time(8'h00, 8'h00, 8'h58, 8'h00);
    wr(ADR_CSEC, 8'h00); wr(ADR_CMIN, 8'h01); wr(ADR_CHR, 8'h00);
    wr(ADR_CMPEN, 8'h07);
    irq_cnt = 0;
    set_run(8'h01, edges, ok);
    wait_sec(7'h59, ok);
    chk(irq_cnt == 0, "R8 partial match no irq", irq_cnt, 0);
    wait_sec(7'h01, ok);
    chk(irq_cnt == 1, "R8 full match 00:01:00", irq_cnt, 1);
    chk(irq_wide == 0, "R8 pulse one cycle", irq_wide, 0);

    // R6 12-hour mode: 11 AM -> 12 PM
    set_run(8'h00, edges, ok);
    wr(ADR_CMPEN, 8'h00);
    wr(ADR_CTRL, 8'h04);
    load_time(8'h11, 8'h59, 8'h59, 8'h02);
    set_run(8'h05, edges, ok);
    wait_sec(7'h00, ok);
    expect_rd(ADR_HOUR, 8'h12, "R6 11 to 12");
    expect_rd(ADR_CTRL, 8'h0F, "R6 PM set");
    expect_rd(ADR_DOW, 8'h02, "R6 day kept at noon");
    // 12 PM -> 01 PM
    set_run(8'h0C, edges, ok);
    load_time(8'h12, 8'h59, 8'h59, 8'h02);
    set_run(8'h0D, edges, ok);
    wait_sec(7'h00, ok);
    expect_rd(ADR_HOUR, 8'h01, "R6 12 to 01");
    expect_rd(ADR_CTRL, 8'h0F, "R6 PM kept");
    // 11 PM -> 12 AM, next day
    set_run(8'h0C, edges, ok);
    load_time(8'h11, 8'h59, 8'h59, 8'h02);
    set_run(8'h0D, edges, ok);
    wait_sec(7'h00, ok);
    expect_rd(ADR_HOUR, 8'h12, "R6 midnight hour");
    expect_rd(ADR_CTRL, 8'h07, "R6 PM cleared");
    expect_rd(ADR_DOW, 8'h03, "R6 day advanced");

    // R7 source select
    measure(0);
    measure(1);
    measure(2);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule